// File: doc/BRIEF.md
# Multi-Program Shader Instruction Store

This block is the on-chip instruction memory of a programmable vertex processor. It holds up to 256 instruction words and can keep several small programs resident at once, each in a contiguous address range. A host write port uploads words. A program-select port latches the first and last address of the program to run. After a start pulse, a fetch port delivers that program's words one at a time over a valid/ready handshake. A program counter walks from the first address to the last. Switching to another resident program only needs a new pair of bounds; nothing is uploaded again.

Jump instructions carry their target as an offset from the program's first address. The fetch logic turns that offset into an absolute address, writes it into the word it delivers and continues from there. A target beyond the program's last address is a fault and stops fetching. The host may keep writing while a program runs, except into the range that is running; such writes are dropped and flagged.

The memory can run as one merged region spanning all 256 words. It can also run in a ping-pong arrangement: the program bounds then select a location inside the active half, and the host fills the other half in the meantime. A swap request exchanges the halves, but only between programs.

Top module: `shd_istore`

## Requirements
- R1: After reset, fet_valid, busy, done, fault and wr_err are low, and bank is 0.
- R2: A write with wr_en high outside the protected range stores wr_data at wr_addr, and later fetches of that address deliver the new word.
- R3: A sel_load pulse while idle (busy low, go low) latches sel_start and sel_end as the program bounds when start is not above end. It has no effect while busy or when start is above end. After a go pulse, busy rises on the next cycle and words are delivered in address order from start to end. Busy then falls and done rises after the word at the end address is issued. Several programs stay resident, and each runs again after only a new sel_load.
- R4: Each delivered word appears on fet_word, with its absolute address on fet_addr, one cycle after it is read. While fet_valid is high and fet_ready is low, fet_valid, fet_word and fet_addr hold steady.
- R5: A word with bit 31 set is a jump whose bits 7:0 are an offset from the program start. The target is start plus offset. The word is delivered with bits 7:0 replaced by the absolute target, and fetching continues at the target.
- R6: A jump whose target exceeds the end address is not delivered. It sets fault, clears busy and halts fetch, and fault stays high until the next go.
- R7: A write while busy whose address lies between the active start and end (inclusive) leaves the memory unchanged, and wr_err is high in the following cycle. An accepted write leaves wr_err low.
- R8: With dbuf_mode high, the effective start and end addresses are {bank, bits 6:0 of the latched bound}, so the same bounds run in whichever half is active.
- R9: A swap_req pulse while idle toggles bank. A swap_req pulse while busy leaves bank unchanged.
- R10: With dbuf_mode low, the bounds address the whole memory, so one program may span both halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write address |
| wr_data | input | 32 | Host write word |
| wr_err | output | 1 | Previous cycle's write was rejected |
| dbuf_mode | input | 1 | 1: ping-pong halves, 0: merged region |
| sel_load | input | 1 | Latch new program bounds |
| sel_start | input | 8 | First address (offset within half in ping-pong mode) |
| sel_end | input | 8 | Last address (offset within half in ping-pong mode) |
| swap_req | input | 1 | Exchange active and upload halves |
| bank | output | 1 | Currently active half |
| go | input | 1 | Start running the selected program |
| fet_ready | input | 1 | Consumer accepts the delivered word |
| fet_valid | output | 1 | fet_word and fet_addr hold a word |
| fet_word | output | 32 | Delivered instruction, with jump target made absolute |
| fet_addr | output | 8 | Absolute address of the delivered word |
| busy | output | 1 | Program is running |
| done | output | 1 | Last program finished normally |
| fault | output | 1 | Last program stopped on an out-of-range jump |

## Verification
The hardest situations to reach are the ones that need a program held in mid-run: a write aimed inside the running range, a swap or bounds load arriving while busy, and output stability under back-pressure. The stimulus starts a long program with fet_ready held low, so the first word stalls at the output and busy stays high. It then issues the protected write, an unprotected write, a rejected swap and a rejected sel_load. Only after that does it drain the program with random ready and compare every beat against a bench model. Random programs with forward jumps at random spots, and one planted out-of-range jump, cover the address arithmetic.

// File: rtl/shd_istore_pkg.sv
package shd_istore_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int HALF_W   = ADDR_W - 1;
    localparam int JUMP_BIT = DATA_W - 1;

    typedef logic [ADDR_W-1:0] iaddr_t;
    typedef logic [DATA_W-1:0] iword_t;

    typedef struct packed {
        iaddr_t lo;
        iaddr_t hi;
    } span_t;

    typedef struct packed {
        iaddr_t addr;
        iword_t word;
    } beat_t;

    function automatic logic is_jump(iword_t w);
        return w[JUMP_BIT];
    endfunction

    function automatic iaddr_t jump_off(iword_t w);
        return w[ADDR_W-1:0];
    endfunction

    function automatic iword_t patch_target(iword_t w, iaddr_t tgt);
        return {w[DATA_W-1:ADDR_W], tgt};
    endfunction

    function automatic iaddr_t place(logic split, logic half, iaddr_t off);
        return split ? {half, off[HALF_W-1:0]} : off;
    endfunction

endpackage

// File: rtl/shd_istore_bounds.sv
module shd_istore_bounds
    import shd_istore_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   busy,
    input  logic   go,
    input  logic   dbuf_mode,
    input  logic   sel_load,
    input  iaddr_t sel_start,
    input  iaddr_t sel_end,
    input  logic   swap_req,
    output span_t  span,
    output logic   bank
);
    iaddr_t st_q, en_q;
    logic   bank_q, mode_q;
    logic   idle, ordered, accept;

    always_comb begin
        idle    = !busy && !go;
        ordered = dbuf_mode ? (sel_start[HALF_W-1:0] <= sel_end[HALF_W-1:0])
                            : (sel_start <= sel_end);
        accept  = sel_load && idle && ordered;
        span.lo = place(mode_q, bank_q, st_q);
        span.hi = place(mode_q, bank_q, en_q);
        bank    = bank_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            en_q   <= '0;
            bank_q <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            if (idle) mode_q <= dbuf_mode;
            if (accept) begin
                st_q <= sel_start;
                en_q <= sel_end;
            end
            if (swap_req && idle) bank_q <= !bank_q;
        end
    end

    AST_BANK_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(bank_q)); // R9
    AST_SPAN_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(span)); // R3

endmodule

// File: rtl/shd_istore_mem.sv
module shd_istore_mem
    import shd_istore_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  iaddr_t wr_addr,
    input  iword_t wr_data,
    input  logic   busy,
    input  span_t  span,
    input  iaddr_t rd_addr,
    output iword_t rd_word,
    output logic   wr_err
);
    iword_t store [DEPTH];
    logic   guarded;
    logic   err_q;

    always_comb begin
        guarded = busy && (wr_addr >= span.lo) && (wr_addr <= span.hi);
        rd_word = store[rd_addr];
        wr_err  = err_q;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !guarded) store[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= wr_en && guarded;
    end

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $past(wr_en) && $past(busy)); // R7

endmodule

// File: rtl/shd_istore_fetch.sv
module shd_istore_fetch
    import shd_istore_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    input  logic   fet_ready,
    input  span_t  span,
    input  iword_t rd_word,
    output iaddr_t rd_addr,
    output logic   fet_valid,
    output iword_t fet_word,
    output iaddr_t fet_addr,
    output logic   busy,
    output logic   done,
    output logic   fault
);
    logic          run_q, ov_q, done_q, fault_q;
    iaddr_t        pc_q;
    beat_t         out_q;
    logic          issue, jump, tgt_bad;
    logic [ADDR_W:0] tgt;

    always_comb begin
        issue     = run_q && (!ov_q || fet_ready);
        jump      = is_jump(rd_word);
        tgt       = {1'b0, span.lo} + {1'b0, jump_off(rd_word)};
        tgt_bad   = tgt > {1'b0, span.hi};
        rd_addr   = pc_q;
        fet_valid = ov_q;
        fet_word  = out_q.word;
        fet_addr  = out_q.addr;
        busy      = run_q;
        done      = done_q;
        fault     = fault_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            ov_q    <= 1'b0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            pc_q    <= '0;
            out_q   <= '0;
        end else begin
            if (ov_q && fet_ready) ov_q <= 1'b0;
            if (issue) begin
                if (jump && tgt_bad) begin
                    run_q   <= 1'b0;
                    fault_q <= 1'b1;
                end else begin
                    ov_q       <= 1'b1;
                    out_q.addr <= pc_q;
                    out_q.word <= jump ? patch_target(rd_word, tgt[ADDR_W-1:0]) : rd_word;
                    if (jump) begin
                        pc_q <= tgt[ADDR_W-1:0];
                    end else if (pc_q == span.hi) begin
                        run_q  <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        pc_q <= pc_q + 1'b1;
                    end
                end
            end else if (go && !run_q) begin
                run_q   <= 1'b1;
                pc_q    <= span.lo;
                done_q  <= 1'b0;
                fault_q <= 1'b0;
            end
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        fet_valid && !fet_ready |=> fet_valid && $stable(fet_word) && $stable(fet_addr)); // R4
    AST_PC_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (pc_q >= span.lo) && (pc_q <= span.hi)); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !run_q && !fault_q); // R3
    AST_FAULT_IDLE: assert property (@(posedge clk) disable iff (rst)
        fault_q |-> !run_q); // R6
    AST_ADDR_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
        run_q && ov_q |-> (fet_addr >= span.lo) && (fet_addr <= span.hi)); // R3

endmodule

// File: rtl/shd_istore.sv
module shd_istore
    import shd_istore_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err,
    input  logic              dbuf_mode,
    input  logic              sel_load,
    input  logic [ADDR_W-1:0] sel_start,
    input  logic [ADDR_W-1:0] sel_end,
    input  logic              swap_req,
    output logic              bank,
    input  logic              go,
    input  logic              fet_ready,
    output logic              fet_valid,
    output logic [DATA_W-1:0] fet_word,
    output logic [ADDR_W-1:0] fet_addr,
    output logic              busy,
    output logic              done,
    output logic              fault
);
    span_t  span;
    iaddr_t rd_addr;
    iword_t rd_word;

    shd_istore_bounds u_bounds (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .go        (go),
        .dbuf_mode (dbuf_mode),
        .sel_load  (sel_load),
        .sel_start (sel_start),
        .sel_end   (sel_end),
        .swap_req  (swap_req),
        .span      (span),
        .bank      (bank)
    );

    shd_istore_mem u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy    (busy),
        .span    (span),
        .rd_addr (rd_addr),
        .rd_word (rd_word),
        .wr_err  (wr_err)
    );

    shd_istore_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .fet_ready (fet_ready),
        .span      (span),
        .rd_word   (rd_word),
        .rd_addr   (rd_addr),
        .fet_valid (fet_valid),
        .fet_word  (fet_word),
        .fet_addr  (fet_addr),
        .busy      (busy),
        .done      (done),
        .fault     (fault)
    );

endmodule

// File: tb/shd_istore_tb.sv
module shd_istore_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_err;
    logic        dbuf_mode = 1'b0;
    logic        sel_load = 1'b0;
    logic [7:0]  sel_start = '0;
    logic [7:0]  sel_end = '0;
    logic        swap_req = 1'b0;
    logic        bank;
    logic        go = 1'b0;
    logic        fet_ready = 1'b0;
    logic        fet_valid;
    logic [31:0] fet_word;
    logic [7:0]  fet_addr;
    logic        busy, done, fault;

    int checks = 0;
    int errors = 0;

    logic [31:0] model [256];
    logic [31:0] exp_w [600];
    logic [7:0]  exp_a [600];
    int          exp_n;
    bit          exp_fault;

    always #10 clk = ~clk;

    shd_istore u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_err(wr_err), .dbuf_mode(dbuf_mode), .sel_load(sel_load),
        .sel_start(sel_start), .sel_end(sel_end), .swap_req(swap_req), .bank(bank),
        .go(go), .fet_ready(fet_ready), .fet_valid(fet_valid), .fet_word(fet_word),
        .fet_addr(fet_addr), .busy(busy), .done(done), .fault(fault)
    );

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d, bit track);
        wr_en = 1'b1; wr_addr = a[7:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (track) model[a] = d;
    endtask

    task automatic sel(int s, int e);
        sel_load = 1'b1; sel_start = s[7:0]; sel_end = e[7:0];
        @(negedge clk);
        sel_load = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_go();
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    // Writes a random program into s..e with forward jumps only.
    task automatic gen_prog(int s, int e);
        for (int a = s; a <= e; a++) begin
            logic [31:0] w;
            w = $urandom & 32'h7fff_ffff;
            if (a < e && ($urandom % 5) == 0) begin
                int span_left;
                int rel;
                span_left = e - a;
                rel = (a - s) + 1 + int'($urandom % ((span_left < 4) ? span_left : 4));
                w = {1'b1, w[30:8], rel[7:0]};
            end
            wr(a, w, 1'b1);
        end
    endtask

    // Reference walk of the program from the bench's own model.
    function automatic void expect_run(int s, int e);
        int pc;
        exp_n = 0;
        exp_fault = 1'b0;
        pc = s;
        for (int g = 0; g < 600; g++) begin
            logic [31:0] w;
            w = model[pc];
            if (w[31]) begin
                int tgt;
                tgt = s + int'(w[7:0]);
                if (tgt > e) begin
                    exp_fault = 1'b1;
                    break;
                end
                exp_w[exp_n] = {w[31:8], tgt[7:0]};
                exp_a[exp_n] = pc[7:0];
                exp_n++;
                pc = tgt;
            end else begin
                exp_w[exp_n] = w;
                exp_a[exp_n] = pc[7:0];
                exp_n++;
                if (pc == e) break;
                pc++;
            end
        end
    endfunction

    task automatic drain(string req, int s, int e, int pct);
        int idx;
        expect_run(s, e);
        idx = 0;
        for (int c = 0; c < 4000; c++) begin
            fet_ready = (pct >= 100) || (($urandom % 100) < pct);
            #1;
            if (fet_valid && fet_ready) begin
                if (idx < exp_n) begin
                    check(fet_word == exp_w[idx], req, "fet_word", fet_word, exp_w[idx]);
                    check(fet_addr == exp_a[idx], req, "fet_addr", fet_addr, exp_a[idx]);
                end else begin
                    check(1'b0, req, "extra beat", idx, exp_n);
                end
                idx++;
            end else if (!busy && !fet_valid) begin
                break;
            end
            @(negedge clk);
        end
        fet_ready = 1'b0;
        check(idx == exp_n, req, "beat count", idx, exp_n);
        check(fault == exp_fault, req, "fault flag", fault, exp_fault);
        check(done == !exp_fault, req, "done flag", done, !exp_fault);
        check(!busy, req, "busy after end", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 256; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset state
        check(!fet_valid && !busy && !done && !fault && !wr_err && !bank, "R1", "reset outputs",
              {fet_valid, busy, done, fault, wr_err, bank}, 0);
        @(negedge clk);

        // Clear the memory so the model matches
        for (int a = 0; a < 256; a++) wr(a, 32'h0, 1'b1);

        // R3 R5 two resident programs, switch without reupload
        gen_prog(1, 23);
        gen_prog(24, 52);
        sel(1, 23);  pulse_go(); drain("R3", 1, 23, 70);
        sel(24, 52); pulse_go(); drain("R5", 24, 52, 50);
        sel(1, 23);  pulse_go(); drain("R3", 1, 23, 100);

        // R6 planted out-of-range jump
        gen_prog(200, 210);
        wr(200, 32'h0000_0011, 1'b1);
        wr(201, 32'h0000_0022, 1'b1);
        wr(202, 32'h8000_000b, 1'b1);
        sel(200, 210); pulse_go(); drain("R6", 200, 210, 100);
        check(fault == 1'b1, "R6", "fault held", fault, 1);

        // R4 R7 R3 R9 activity while a program is stalled
        gen_prog(60, 90);
        for (int a = 60; a < 90; a++) if (model[a][31]) wr(a, model[a] & 32'h7fff_ffff, 1'b1);
        sel(60, 90);
        pulse_go();
        @(negedge clk); @(negedge clk);
        #1;
        check(busy && fet_valid, "R4", "stalled valid", {busy, fet_valid}, 2'b11);
        check(fet_addr == 8'd60, "R4", "stalled addr", fet_addr, 60);
        held = fet_word;
        @(negedge clk);
        #1;
        check(fet_valid && fet_word == held, "R4", "word held under stall", fet_word, held);
        wr(70, 32'h1234_5678, 1'b0);
        #1;
        check(wr_err == 1'b1, "R7", "protected write flagged", wr_err, 1);
        wr(10, 32'h0abc_def0, 1'b1);
        #1;
        check(wr_err == 1'b0, "R7", "outside write accepted", wr_err, 0);
        swap_req = 1'b1;
        @(negedge clk);
        swap_req = 1'b0;
        #1;
        check(bank == 1'b0, "R9", "swap ignored while busy", bank, 0);
        sel(120, 125);
        drain("R7", 60, 90, 60);
        // bounds unchanged by the busy sel_load: same program runs again
        pulse_go(); drain("R3", 60, 90, 100);
        // R2 the accepted write is visible
        sel(1, 12); pulse_go(); drain("R2", 1, 12, 80);
        // R3 start above end is ignored
        sel(50, 40); pulse_go(); drain("R3", 1, 12, 100);

        // R10 merged region spanning both halves
        gen_prog(100, 200);
        sel(100, 200); pulse_go(); drain("R10", 100, 200, 75);

        // R8 R9 ping-pong halves
        dbuf_mode = 1'b1;
        @(negedge clk); @(negedge clk);
        gen_prog(5, 30);
        gen_prog(133, 158);
        sel(5, 30);
        pulse_go();
        @(negedge clk);
        wr(140, 32'h0055_aa00, 1'b1);
        #1;
        check(wr_err == 1'b0, "R8", "upload into idle half", wr_err, 0);
        swap_req = 1'b1;
        @(negedge clk);
        swap_req = 1'b0;
        #1;
        check(bank == 1'b0, "R9", "swap ignored while busy", bank, 0);
        drain("R8", 5, 30, 70);
        swap_req = 1'b1;
        @(negedge clk);
        swap_req = 1'b0;
        #1;
        check(bank == 1'b1, "R9", "swap while idle", bank, 1);
        @(negedge clk);
        pulse_go(); drain("R8", 133, 158, 70);
        dbuf_mode = 1'b0;
        @(negedge clk); @(negedge clk);

        // R3 R5 random resident programs in the merged region
        for (int it = 0; it < 8; it++) begin
            int s;
            int len;
            s = int'($urandom % 200);
            len = 1 + int'($urandom % 40);
            if (s + len > 255) len = 255 - s;
            gen_prog(s, s + len);
            sel(s, s + len); pulse_go(); drain("R5", s, s + len, 30 + int'($urandom % 70));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule